// File: doc/BRIEF.md
# Programmable Sum-of-Products Logic Array

This block is the logic core of a small field-programmable logic device. Ten dedicated inputs and eight feedback/input signals are expanded into thirty-six array lines, each signal in true and complement form. A connection matrix decides which lines reach each of seventy-four product terms. Each product term is a wide AND of its connected lines. Sixty-four of the terms feed eight fixed OR gates, eight at a time. Eight further terms act as per-output enables. The last two terms are a global preset term and a global clear term. The evaluation path is purely combinational.

The connection matrix is the only state. It is loaded as a stream of 36-bit row words over a valid/ready port, and each accepted word shifts into the chain. An erase pulse opens every connection in one cycle. While erase is high, `cfg_ready_o` is low, so the source must hold its word until the erase pulse ends. Macrocells, pin drivers and non-volatile storage sit outside this block.

Top module: `pla_sop_array`

## Requirements
- R1: Array line 2k carries signal k and line 2k+1 carries its complement. Signals 0..9 are `ded_i[0..9]` and signals 10..17 are `fb_i[0..7]`. A row bit of 1 connects that line. A product term is the AND of all of its connected lines.
- R2: A product term with every connection open evaluates TRUE.
- R3: A product term connected to both the true and complement line of any one signal evaluates FALSE, whatever the inputs.
- R4: `sum_o[g]` is the OR of product terms 8g through 8g+7.
- R5: `oe_o[k]` is product term 64+k. `preset_o` is term 72. `clear_o` is term 73.
- R6: Each accepted word (`cfg_valid_i && cfg_ready_o` at a rising edge) enters row 0 and moves every other row up by one. After 74 accepted words, the first word sent is row 73, so rows are sent from 73 down to 0.
- R7: An erase pulse opens every connection at the next edge, which drives all outputs to 1. `cfg_ready_o` is low while `erase_i` is high, and a word offered in that cycle is not taken.
- R8: After reset, every connection is open and all outputs read 1.
- R9: When no word is accepted and erase is low, the connection matrix holds its value across clock edges.
- R10: The outputs follow changes on `ded_i` and `fb_i` in the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the connection matrix |
| rst_ni | input | 1 | Asynchronous active-low reset; sets all connections open |
| erase_i | input | 1 | Opens every connection at the next edge |
| cfg_valid_i | input | 1 | A configuration row word is offered |
| cfg_ready_o | output | 1 | A word can be accepted (low during erase) |
| cfg_data_i | input | 36 | Row word, bit n is the connection to array line n |
| ded_i | input | 10 | Dedicated inputs |
| fb_i | input | 8 | Feedback/input signals |
| sum_o | output | 8 | OR-array sums |
| oe_o | output | 8 | Output-enable terms |
| preset_o | output | 1 | Preset term |
| clear_o | output | 1 | Clear term |

## Verification
Two configuration functions can land in the same cycle: an erase, and an offered row word with valid high. The bench raises both together and checks that ready is low in that cycle. It then checks that the matrix comes back fully open: all outputs read 1, and none of the offered word's contradiction shows up. The array is also checked against a bench model after random, all-open, contradictory and single-row loads.

// File: rtl/pla_pkg.sv
package pla_pkg;
  localparam int unsigned DEF_N_DED         = 10;
  localparam int unsigned DEF_N_FB          = 8;
  localparam int unsigned DEF_N_SUM         = 8;
  localparam int unsigned DEF_TERMS_PER_SUM = 8;

  // Line index of the true form of signal k; the complement sits one above.
  function automatic int unsigned true_line(int unsigned k);
    return 2 * k;
  endfunction
endpackage

// File: rtl/pla_line_gen.sv
module pla_line_gen #(
  parameter int unsigned N_SIG = 18,
  localparam int unsigned N_LINE = 2 * N_SIG
) (
  input  logic [N_SIG-1:0]  sig_i,
  output logic [N_LINE-1:0] lines_o
);
  for (genvar k = 0; k < N_SIG; k++) begin : g_sig
    assign lines_o[pla_pkg::true_line(k)]     = sig_i[k];
    assign lines_o[pla_pkg::true_line(k) + 1] = ~sig_i[k];
  end
endmodule

// File: rtl/pla_cfg_store.sv
module pla_cfg_store #(
  parameter int unsigned N_LINE = 36,
  parameter int unsigned N_TERM = 74,
  localparam int unsigned N_BITS = N_LINE * N_TERM
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              erase_i,
  input  logic              wr_valid_i,
  output logic              wr_ready_o,
  input  logic [N_LINE-1:0] wr_data_i,
  output logic [N_BITS-1:0] conn_o
);
  logic [N_BITS-1:0] conn_q;
  logic              take;

  assign wr_ready_o = ~erase_i;
  assign take       = wr_valid_i & wr_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      conn_q <= '0;
    end else if (erase_i) begin
      conn_q <= '0;
    end else if (take) begin
      conn_q <= {conn_q[N_BITS-N_LINE-1:0], wr_data_i};
    end
  end

  assign conn_o = conn_q;

  p_word_enters_row0_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take |=> conn_q[N_LINE-1:0] == $past(wr_data_i));

  p_row_moves_up_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take |=> conn_q[2*N_LINE-1:N_LINE] == $past(conn_q[N_LINE-1:0]));

  p_hold_without_handshake_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!take && !erase_i) |=> $stable(conn_q));
endmodule

// File: rtl/pla_product_term.sv
module pla_product_term #(
  parameter int unsigned N_LINE = 36,
  localparam int unsigned N_SIG = N_LINE / 2
) (
  input  logic [N_LINE-1:0] conn_i,
  input  logic [N_LINE-1:0] lines_i,
  output logic              term_o
);
  // An open connection contributes a 1 to the AND.
  assign term_o = &(~conn_i | lines_i);

  logic [N_SIG-1:0] both_forms;
  for (genvar k = 0; k < N_SIG; k++) begin : g_pair
    assign both_forms[k] = conn_i[2*k] & conn_i[2*k+1];
  end

  always_comb begin
    if (conn_i == '0) begin
      p_all_open_true_r2: assert (term_o == 1'b1);
    end
    if (|both_forms) begin
      p_contradiction_false_r3: assert (term_o == 1'b0);
    end
  end
endmodule

// File: rtl/pla_sop_array.sv
module pla_sop_array #(
  parameter int unsigned N_DED         = pla_pkg::DEF_N_DED,
  parameter int unsigned N_FB          = pla_pkg::DEF_N_FB,
  parameter int unsigned N_SUM         = pla_pkg::DEF_N_SUM,
  parameter int unsigned TERMS_PER_SUM = pla_pkg::DEF_TERMS_PER_SUM,
  localparam int unsigned N_SIG      = N_DED + N_FB,
  localparam int unsigned N_LINE     = 2 * N_SIG,
  localparam int unsigned N_PROD     = N_SUM * TERMS_PER_SUM,
  localparam int unsigned IDX_PRESET = N_PROD + N_SUM,
  localparam int unsigned IDX_CLEAR  = IDX_PRESET + 1,
  localparam int unsigned N_TERM     = IDX_CLEAR + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              erase_i,
  input  logic              cfg_valid_i,
  output logic              cfg_ready_o,
  input  logic [N_LINE-1:0] cfg_data_i,
  input  logic [N_DED-1:0]  ded_i,
  input  logic [N_FB-1:0]   fb_i,
  output logic [N_SUM-1:0]  sum_o,
  output logic [N_SUM-1:0]  oe_o,
  output logic              preset_o,
  output logic              clear_o
);
  logic [N_LINE*N_TERM-1:0] conn;
  logic [N_LINE-1:0]        lines;
  logic [N_TERM-1:0]        terms;

  pla_cfg_store #(.N_LINE(N_LINE), .N_TERM(N_TERM)) u_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .erase_i    (erase_i),
    .wr_valid_i (cfg_valid_i),
    .wr_ready_o (cfg_ready_o),
    .wr_data_i  (cfg_data_i),
    .conn_o     (conn)
  );

  pla_line_gen #(.N_SIG(N_SIG)) u_lines (
    .sig_i   ({fb_i, ded_i}),
    .lines_o (lines)
  );

  for (genvar t = 0; t < N_TERM; t++) begin : g_term
    pla_product_term #(.N_LINE(N_LINE)) u_term (
      .conn_i  (conn[t*N_LINE +: N_LINE]),
      .lines_i (lines),
      .term_o  (terms[t])
    );
  end

  for (genvar g = 0; g < N_SUM; g++) begin : g_sum
    assign sum_o[g] = |terms[g*TERMS_PER_SUM +: TERMS_PER_SUM];
    assign oe_o[g]  = terms[N_PROD + g];
  end

  assign preset_o = terms[IDX_PRESET];
  assign clear_o  = terms[IDX_CLEAR];

  p_erase_opens_all_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    erase_i |=> (&sum_o && &oe_o && preset_o && clear_o));
endmodule

// File: tb/tb_pla_sop_array.sv
module tb_pla_sop_array;
  localparam int NT = 74;
  localparam int NL = 36;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          erase = 1'b0;
  logic          cfg_valid = 1'b0;
  logic          cfg_ready;
  logic [NL-1:0] cfg_data = '0;
  logic [9:0]    ded = '0;
  logic [7:0]    fb = '0;
  logic [7:0]    sum, oe;
  logic          pre, clr;

  always #4 clk = ~clk;

  pla_sop_array dut (
    .clk_i(clk), .rst_ni(rst_n), .erase_i(erase), .cfg_valid_i(cfg_valid),
    .cfg_ready_o(cfg_ready), .cfg_data_i(cfg_data), .ded_i(ded), .fb_i(fb),
    .sum_o(sum), .oe_o(oe), .preset_o(pre), .clear_o(clr)
  );

  typedef struct { string tag; logic [17:0] exp; } item_t;
  item_t sb[$];
  logic [NL-1:0] model [NT];
  int n_chk = 0;
  int n_fail = 0;

  task automatic score(input string tag, input logic [17:0] act, input logic [17:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [17:0] exp_out(input logic [9:0] d, input logic [7:0] f);
    logic [17:0] sig;
    logic [NL-1:0] ln;
    logic [NT-1:0] tm;
    logic [7:0] s;
    sig = {f, d};
    for (int k = 0; k < 18; k++) begin
      ln[2*k]   = sig[k];
      ln[2*k+1] = ~sig[k];
    end
    for (int t = 0; t < NT; t++) tm[t] = &(~model[t] | ln);
    for (int g = 0; g < 8; g++) s[g] = |tm[g*8 +: 8];
    return {tm[73], tm[72], tm[71:64], s};
  endfunction

  task automatic apply(input logic [9:0] d, input logic [7:0] f, input string tag);
    item_t it;
    @(posedge clk); #1;
    ded = d; fb = f;
    it.tag = tag; it.exp = exp_out(d, f);
    sb.push_back(it);
  endtask

  task automatic push_word(input logic [NL-1:0] w);
    @(posedge clk); #1;
    cfg_valid = 1'b1; cfg_data = w;
    @(posedge clk); #1;
    cfg_valid = 1'b0;
    for (int t = NT - 1; t > 0; t--) model[t] = model[t-1];
    model[0] = w;
  endtask

  task automatic load_model();
    logic [NL-1:0] img [NT];
    for (int t = 0; t < NT; t++) img[t] = model[t];
    for (int t = NT - 1; t >= 0; t--) push_word(img[t]);
  endtask

  task automatic clear_model();
    for (int t = 0; t < NT; t++) model[t] = '0;
  endtask

  // Monitor: compares outputs away from the edge that drove inputs.
  initial begin
    item_t it;
    forever begin
      @(negedge clk);
      while (sb.size() > 0) begin
        it = sb.pop_front();
        score(it.tag, {clr, pre, oe, sum}, it.exp);
      end
    end
  end

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    clear_model();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R8: reset state, all open
    apply(10'h000, 8'h00, "R8 reset open");
    apply(10'h3ff, 8'hff, "R8 reset open");
    apply(10'h155, 8'h2a, "R2 open terms true");

    // R1 R4 R5 R6: random sparse configurations
    for (int c = 0; c < 6; c++) begin
      for (int t = 0; t < NT; t++)
        for (int b = 0; b < NL; b++) model[t][b] = ($urandom % 16) == 0;
      load_model();
      for (int v = 0; v < 20; v++)
        apply(10'($urandom), 8'($urandom), "R1 R4 R5 random array");
    end

    // R10: input changes every cycle, no clock between change and sample
    for (int v = 0; v < 10; v++) apply(10'($urandom), 8'($urandom), "R10 combinational");

    // R3 and R2: every term contradictory except term 5 open
    for (int t = 0; t < NT; t++) model[t] = 36'h3 << (2 * (t % 18));
    model[5] = '0;
    load_model();
    for (int v = 0; v < 8; v++) apply(10'($urandom), 8'($urandom), "R3 contradiction false");

    // R9: offered data with valid low does not change the array
    @(posedge clk); #1 cfg_data = '1;
    repeat (4) @(posedge clk);
    apply(10'h0f0, 8'h3c, "R9 hold");

    // R7: erase and a valid word in the same cycle; erase wins
    @(posedge clk); #1;
    erase = 1'b1; cfg_valid = 1'b1; cfg_data = 36'h3;
    #1 score("R7 ready low during erase", {17'b0, cfg_ready}, 18'b0);
    @(posedge clk); #1;
    erase = 1'b0; cfg_valid = 1'b0;
    clear_model();
    apply(10'h2aa, 8'h55, "R7 erase opens all");
    apply(10'h000, 8'hff, "R7 erase opens all");

    // R6: one word lands in row 0 only
    push_word(36'h3 << 20);
    apply(10'h001, 8'h00, "R6 single word row0");

    // R6: full load with only the clear term contradictory -> order 73 first
    clear_model();
    model[73] = 36'hc;
    load_model();
    apply(10'h3ff, 8'h81, "R6 first word is row 73");

    // R5: distinct enable, preset and clear terms
    clear_model();
    for (int t = 0; t < 64; t++) model[t] = 36'h3;
    for (int k = 0; k < 8; k++) model[64 + k] = 36'h1 << (2 * k); // oe k = ded[k]
    model[72] = 36'h1 << 20;                                      // fb[0]
    model[73] = 36'h2 << 22;                                      // ~fb[1]
    load_model();
    apply(10'h0a5, 8'h01, "R5 control terms");
    apply(10'h15a, 8'h02, "R5 control terms");

    repeat (3) @(posedge clk);
    finish_run();
  end
endmodule